// File: doc/BRIEF.md
# Strobed Handshake Port Channel

This block is one parallel port channel of width `DATA_W` whose transfers are paced by a handshake with an external peripheral. The `mode_out` input chooses the direction at run time. In input mode, the peripheral pulls `strobe_n` low to load the pin data into an input latch. The block then raises `ibf`, and it can raise `intr` until the host reads the latched word. In output mode, a host write loads the output latch and drives it onto the pins. It also pulls the active-low `obf_n` flag low, and a low pulse on `strobe_n` from the peripheral (now acting as acknowledge) releases the flag. It can then interrupt the host to ask for the next word.

The host strobes (`host_rd_n`, `host_wr_n`), the peripheral strobe and the data words on the pins and on the host bus all come from outside the clock domain. Each one passes through a synchroniser that is `SYNC_STAGES` deep. Edges are then detected in the system clock. At 50 MHz with two stages, a 100 ns strobe is several clocks wide, so no pulse is lost. Address decoding on the host bus is not part of this block. `host_rd_n` and `host_wr_n` are assumed to be already qualified for this channel.

Top module: `pch_port_channel`

## Requirements
- R1: After reset, `ibf`=0, `obf_n`=1, `intr`=0, the interrupt enable is 0, `host_rdata`=0, `pin_out`=0 and `status`=0.
- R2: In input mode, `host_rdata` follows `pin_in` for as long as `strobe_n` is low. After `strobe_n` returns high, `host_rdata` keeps the last word captured, even if `pin_in` changes.
- R3: In input mode, `ibf` rises after a falling edge of `strobe_n` and falls after a rising edge of `host_rd_n`.
- R4: In input mode, `intr` rises after a rising edge of `strobe_n` when `ibf` is 1 and the enable is 1. It falls after a falling edge of `host_rd_n`, while `ibf` stays 1 until the read ends.
- R5: In output mode, a rising edge of `host_wr_n` loads `host_wdata` into the output latch. This drives `pin_out` and pulls `obf_n` low. A falling edge of `strobe_n` returns `obf_n` high. `pin_oe` is 1 in output mode.
- R6: In output mode, `intr` rises after a rising edge of `strobe_n` when `obf_n` is 1 and the enable is 1. It falls after a falling edge of `host_wr_n`.
- R7: A one-cycle pulse on `inte_set` sets the enable and one on `inte_clr` clears it. When both pulse in the same cycle, the clear wins. While the enable is 0, `intr` is 0 from the next cycle on, whatever the state of the buffer.
- R8: A new strobe that arrives while `ibf` is 1 overwrites the input latch, and `ibf` stays 1.
- R9: In input mode, when a strobe falling edge and a read rising edge land in the same cycle, `ibf` ends at 1. When a strobe rising edge and a read falling edge land in the same cycle, `intr` is set.
- R10: In output mode, when a write rising edge and a strobe falling edge land in the same cycle, `obf_n` ends at 0. When a strobe rising edge and a write falling edge land in the same cycle, `intr` stays 0.
- R11: A change of `mode_out` clears both data latches, sets `ibf`=0, `obf_n`=1 and `intr`=0, and keeps the enable. The status bits are: `status[3]` = direction (1 = output), `status[2]` = enable, `status[1]` = `intr`, `status[0]` = buffer full (`ibf` in input mode, inverted `obf_n` in output mode).
- R12: An edge on `strobe_n`, `host_rd_n` or `host_wr_n` that is driven between clock edges changes the outputs on the third rising clock edge after it, and not before.
- R13: Host writes have no effect on `obf_n` or `pin_out` in input mode. In output mode, host reads and `strobe_n` have no effect on `ibf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_out | input | 1 | Direction: 0 input channel, 1 output channel |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_wdata | input | DATA_W | Word written by the host |
| host_rdata | output | DATA_W | Input latch contents presented to the host |
| inte_set | input | 1 | One-cycle pulse that sets the interrupt enable |
| inte_clr | input | 1 | One-cycle pulse that clears the interrupt enable |
| strobe_n | input | 1 | Peripheral strobe (input mode) or acknowledge (output mode), active low |
| pin_in | input | DATA_W | Data on the peripheral pins |
| pin_out | output | DATA_W | Output latch driven toward the pins |
| pin_oe | output | 1 | Pin drive enable |
| ibf | output | 1 | Input buffer full |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Interrupt request to the host |
| status | output | 4 | {direction, enable, intr, buffer full} |

## Verification
The host strobe and the peripheral strobe go through synchronisers of the same depth, so they can act in the same cycle. In input mode, a strobe can start while a read ends, or end while a read starts. In output mode, a write can end as an acknowledge starts, or start as one ends. The bench drives both pins on the same falling clock edge, which forces their edges into one internal cycle. It then checks the resolved flags against the rule that the newer data event wins in the flags, while an interrupt that a write has begun to retire stays low.

// File: rtl/pch_pkg.sv
`timescale 1ns/1ps
package pch_pkg;

  typedef enum logic {
    MODE_IN  = 1'b0,
    MODE_OUT = 1'b1
  } pch_mode_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } pch_edge_t;

  // bit positions of the control strobes inside the synchroniser vector
  localparam int CI_STB = 0;
  localparam int CI_RD  = 1;
  localparam int CI_WR  = 2;
  localparam int CTRL_W = 3;

endpackage

// File: rtl/pch_sync.sv
`timescale 1ns/1ps
module pch_sync
  import pch_pkg::*;
#(
  parameter int STAGES = 2,
  parameter int CW     = 3,
  parameter int PW     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CW-1:0]         ctrl_i,
  input  logic [PW-1:0]         pay_i,
  output pch_edge_t [CW-1:0]    edge_o,
  output logic [PW-1:0]         pay_o
);

  localparam int LAST = STAGES - 1;

  logic [CW-1:0] cs [STAGES];
  logic [PW-1:0] ps [STAGES];
  logic [CW-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cs[s] <= '1;
          ps[s] <= '0;
        end else begin
          cs[s] <= ctrl_i;
          ps[s] <= pay_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cs[s] <= '1;
          ps[s] <= '0;
        end else begin
          cs[s] <= cs[s-1];
          ps[s] <= ps[s-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= cs[LAST];
  end

  for (genvar i = 0; i < CW; i++) begin : g_edge
    assign edge_o[i].fall = prev_q[i] & ~cs[LAST][i];
    assign edge_o[i].rise = ~prev_q[i] & cs[LAST][i];
  end

  assign pay_o = ps[LAST];

endmodule

// File: rtl/pch_in_side.sv
`timescale 1ns/1ps
module pch_in_side
  import pch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              flush_i,
  input  logic              inte_i,
  input  pch_edge_t         stb_i,
  input  pch_edge_t         rd_i,
  input  logic [DATA_W-1:0] pdata_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ibf_o,
  output logic              intr_o
);

  logic [DATA_W-1:0] data_q, data_n;
  logic              low_q, low_n;
  logic              ibf_q, ibf_n;
  logic              intr_q, intr_n;
  logic              stb_fall, stb_rise, rd_fall, rd_rise;

  assign stb_fall = stb_i.fall;
  assign stb_rise = stb_i.rise;
  assign rd_fall  = rd_i.fall;
  assign rd_rise  = rd_i.rise;

  always_comb begin
    data_n = data_q;
    low_n  = low_q;
    ibf_n  = ibf_q;
    intr_n = intr_q;
    if (flush_i) begin
      data_n = '0;
      low_n  = 1'b0;
      ibf_n  = 1'b0;
      intr_n = 1'b0;
    end else if (en_i) begin
      if (stb_fall)      low_n = 1'b1;
      else if (stb_rise) low_n = 1'b0;
      if (stb_fall || low_q) data_n = pdata_i;
      // strobe wins over a read that ends in the same cycle
      if (rd_rise)  ibf_n = 1'b0;
      if (stb_fall) ibf_n = 1'b1;
      if (rd_fall)  intr_n = 1'b0;
      if (stb_rise && ibf_q && inte_i) intr_n = 1'b1;
    end
    if (!inte_i) intr_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      low_q  <= 1'b0;
      ibf_q  <= 1'b0;
      intr_q <= 1'b0;
    end else begin
      data_q <= data_n;
      low_q  <= low_n;
      ibf_q  <= ibf_n;
      intr_q <= intr_n;
    end
  end

  assign data_o = data_q;
  assign ibf_o  = ibf_q;
  assign intr_o = intr_q;

  p_ibf_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibf_q) |-> $past(stb_fall && en_i));

  p_intr_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_q) |-> $past(stb_rise && ibf_q && inte_i));

  p_hold_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ibf_q && stb_fall && en_i && !flush_i) |=> ibf_q);

endmodule

// File: rtl/pch_out_side.sv
`timescale 1ns/1ps
module pch_out_side
  import pch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              flush_i,
  input  logic              inte_i,
  input  pch_edge_t         ack_i,
  input  pch_edge_t         wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] data_o,
  output logic              obf_n_o,
  output logic              intr_o
);

  logic [DATA_W-1:0] data_q, data_n;
  logic              obf_n_q, obf_n_n;
  logic              intr_q, intr_n;
  logic              ack_fall, ack_rise, wr_fall, wr_rise;

  assign ack_fall = ack_i.fall;
  assign ack_rise = ack_i.rise;
  assign wr_fall  = wr_i.fall;
  assign wr_rise  = wr_i.rise;

  always_comb begin
    data_n  = data_q;
    obf_n_n = obf_n_q;
    intr_n  = intr_q;
    if (flush_i) begin
      data_n  = '0;
      obf_n_n = 1'b1;
      intr_n  = 1'b0;
    end else if (en_i) begin
      if (wr_rise) data_n = wdata_i;
      // a fresh write keeps the buffer marked full
      if (ack_fall) obf_n_n = 1'b1;
      if (wr_rise)  obf_n_n = 1'b0;
      if (ack_rise && obf_n_q && inte_i) intr_n = 1'b1;
      if (wr_fall)  intr_n = 1'b0;
    end
    if (!inte_i) intr_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      obf_n_q <= 1'b1;
      intr_q  <= 1'b0;
    end else begin
      data_q  <= data_n;
      obf_n_q <= obf_n_n;
      intr_q  <= intr_n;
    end
  end

  assign data_o  = data_q;
  assign obf_n_o = obf_n_q;
  assign intr_o  = intr_q;

  p_obf_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(obf_n_q) |-> $past(wr_rise && en_i));

  p_intr_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_q) |-> $past(ack_rise && obf_n_q));

  p_wr_retire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fall && en_i && !flush_i) |=> !intr_q);

endmodule

// File: rtl/pch_port_channel.sv
`timescale 1ns/1ps
module pch_port_channel
  import pch_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_out,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              inte_set,
  input  logic              inte_clr,
  input  logic              strobe_n,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic              pin_oe,
  output logic              ibf,
  output logic              obf_n,
  output logic              intr,
  output logic [3:0]        status
);

  localparam int PAY_W = 2 * DATA_W;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [CTRL_W-1:0]         ctrl_raw;
  pch_edge_t [CTRL_W-1:0]    edges;
  logic [PAY_W-1:0]          pay_sync;

  always_comb begin
    ctrl_raw         = '1;
    ctrl_raw[CI_STB] = strobe_n;
    ctrl_raw[CI_RD]  = host_rd_n;
    ctrl_raw[CI_WR]  = host_wr_n;
  end

  pch_sync #(
    .STAGES (SYNC_STAGES),
    .CW     (CTRL_W),
    .PW     (PAY_W)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ctrl_i (ctrl_raw),
    .pay_i  ({host_wdata, pin_in}),
    .edge_o (edges),
    .pay_o  (pay_sync)
  );

  // direction and interrupt enable
  pch_mode_e mode_q, mode_n;
  logic      inte_q, inte_n;
  logic      flush;

  assign flush = (pch_mode_e'(mode_out) != mode_q);

  always_comb begin
    mode_n = pch_mode_e'(mode_out);
    inte_n = inte_q;
    if (inte_set) inte_n = 1'b1;
    if (inte_clr) inte_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= MODE_IN;
      inte_q <= 1'b0;
    end else begin
      mode_q <= mode_n;
      inte_q <= inte_n;
    end
  end

  logic [DATA_W-1:0] in_data, out_data;
  logic              in_ibf, in_intr, out_obf_n, out_intr;

  pch_in_side #(.DATA_W(DATA_W)) u_in (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en_i    (pch_mode_e'(mode_out) == MODE_IN),
    .flush_i (flush),
    .inte_i  (inte_q),
    .stb_i   (edges[CI_STB]),
    .rd_i    (edges[CI_RD]),
    .pdata_i (pay_sync[DATA_W-1:0]),
    .data_o  (in_data),
    .ibf_o   (in_ibf),
    .intr_o  (in_intr)
  );

  pch_out_side #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en_i    (pch_mode_e'(mode_out) == MODE_OUT),
    .flush_i (flush),
    .inte_i  (inte_q),
    .ack_i   (edges[CI_STB]),
    .wr_i    (edges[CI_WR]),
    .wdata_i (pay_sync[PAY_W-1:DATA_W]),
    .data_o  (out_data),
    .obf_n_o (out_obf_n),
    .intr_o  (out_intr)
  );

  assign host_rdata = in_data;
  assign pin_out    = out_data;
  assign pin_oe     = (mode_q == MODE_OUT);
  assign ibf        = in_ibf;
  assign obf_n      = out_obf_n;
  assign intr       = in_intr | out_intr;
  assign status     = {(mode_q == MODE_OUT), inte_q, intr,
                       (mode_q == MODE_OUT) ? ~out_obf_n : in_ibf};

  p_inte_gate_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !inte_q |=> !intr);

  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush |=> (!ibf && obf_n && !intr));

  p_one_side_r13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q == MODE_OUT) |-> !in_ibf);

endmodule

// File: tb/tb_pch_port_channel.sv
`timescale 1ns/1ps
module tb_pch_port_channel;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         mode_out;
  logic         host_rd_n, host_wr_n;
  logic [W-1:0] host_wdata, host_rdata;
  logic         inte_set, inte_clr;
  logic         strobe_n;
  logic [W-1:0] pin_in, pin_out;
  logic         pin_oe, ibf, obf_n, intr;
  logic [3:0]   status;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pch_port_channel #(.DATA_W(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .mode_out(mode_out),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .inte_set(inte_set), .inte_clr(inte_clr),
    .strobe_n(strobe_n), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .ibf(ibf), .obf_n(obf_n), .intr(intr),
    .status(status)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_inte(input bit set_it, input bit clr_it);
    inte_set = set_it;
    inte_clr = clr_it;
    tick(1);
    inte_set = 1'b0;
    inte_clr = 1'b0;
    tick(2);
  endtask

  task automatic t_reset;
    chk("R1 ibf", ibf, 0);
    chk("R1 obf_n", obf_n, 1);
    chk("R1 intr", intr, 0);
    chk("R1 status", status, 4'b0000);
    chk("R1 rdata", host_rdata, 0);
    chk("R1 pin_out", pin_out, 0);
  endtask

  task automatic t_in_basic;
    pulse_inte(1, 0);
    chk("R7 enable set", status[2], 1);
    pin_in   = 8'hA5;
    strobe_n = 1'b0;
    tick(2);
    chk("R12 ibf not yet", ibf, 0);
    tick(1);
    chk("R12 ibf on third edge", ibf, 1);
    chk("R3 ibf after strobe fall", ibf, 1);
    chk("R2 capture first", host_rdata, 8'hA5);
    pin_in = 8'h3C;
    tick(4);
    chk("R2 follows while low", host_rdata, 8'h3C);
    strobe_n = 1'b1;
    tick(2);
    chk("R4 intr not yet", intr, 0);
    tick(1);
    chk("R4 intr after strobe rise", intr, 1);
    tick(2);
    pin_in = 8'hFF;
    tick(4);
    chk("R2 latch holds", host_rdata, 8'h3C);
    chk("R11 status input full", status, 4'b0111);
    host_rd_n = 1'b0;
    tick(4);
    chk("R4 intr cleared on read start", intr, 0);
    chk("R4 ibf kept during read", ibf, 1);
    host_rd_n = 1'b1;
    tick(4);
    chk("R3 ibf cleared on read end", ibf, 0);
  endtask

  task automatic t_in_overwrite;
    pin_in = 8'h11; strobe_n = 1'b0; tick(4);
    strobe_n = 1'b1; tick(4);
    chk("R8 first word full", ibf, 1);
    pin_in = 8'h22; strobe_n = 1'b0; tick(4);
    chk("R8 ibf stays", ibf, 1);
    chk("R8 overwritten", host_rdata, 8'h22);
    strobe_n = 1'b1; tick(4);
    host_rd_n = 1'b0; tick(4);
    host_rd_n = 1'b1; tick(4);
    chk("R8 drained", ibf, 0);
  endtask

  task automatic t_inte;
    pulse_inte(0, 1);
    chk("R7 enable cleared", status[2], 0);
    pin_in = 8'h44; strobe_n = 1'b0; tick(4);
    strobe_n = 1'b1; tick(4);
    chk("R7 no intr while disabled", intr, 0);
    chk("R7 ibf still set", ibf, 1);
    pulse_inte(1, 0);
    chk("R7 enabling raises nothing", intr, 0);
    host_rd_n = 1'b0; tick(4);
    host_rd_n = 1'b1; tick(4);
    pin_in = 8'h45; strobe_n = 1'b0; tick(4);
    strobe_n = 1'b1; tick(4);
    chk("R4 intr again", intr, 1);
    pulse_inte(0, 1);
    chk("R7 clear drops intr", intr, 0);
    pulse_inte(1, 1);
    chk("R7 clear wins", status[2], 0);
    pulse_inte(1, 0);
    host_rd_n = 1'b0; tick(4);
    host_rd_n = 1'b1; tick(4);
  endtask

  task automatic t_in_race;
    pin_in = 8'h66; strobe_n = 1'b0; tick(4);
    strobe_n = 1'b1; tick(4);
    host_rd_n = 1'b0; tick(4);
    host_rd_n = 1'b1; strobe_n = 1'b0; pin_in = 8'h77;
    tick(4);
    chk("R9 strobe beats read end", ibf, 1);
    chk("R9 new word", host_rdata, 8'h77);
    strobe_n = 1'b1; host_rd_n = 1'b0;
    tick(4);
    chk("R9 strobe end beats read start", intr, 1);
    host_rd_n = 1'b1; tick(4);
    chk("R9 read end clears ibf", ibf, 0);
    host_rd_n = 1'b0; tick(4);
    chk("R4 next read clears intr", intr, 0);
    host_rd_n = 1'b1; tick(4);
  endtask

  task automatic t_mode_switch_in;
    host_wdata = 8'hAA; host_wr_n = 1'b0; tick(4);
    host_wr_n = 1'b1; tick(4);
    chk("R13 write ignored obf_n", obf_n, 1);
    chk("R13 write ignored pin_out", pin_out, 0);
    pin_in = 8'h99; strobe_n = 1'b0; tick(4);
    strobe_n = 1'b1; tick(4);
    mode_out = 1'b1;
    tick(2);
    chk("R11 ibf flushed", ibf, 0);
    chk("R11 intr flushed", intr, 0);
    chk("R11 latch flushed", host_rdata, 0);
    chk("R11 status output idle", status, 4'b1100);
    chk("R5 pins driven", pin_oe, 1);
  endtask

  task automatic t_out_basic;
    host_wdata = 8'h5A; host_wr_n = 1'b0; tick(4);
    chk("R6 no intr yet", intr, 0);
    host_wr_n = 1'b1;
    tick(2);
    chk("R12 obf_n not yet", obf_n, 1);
    tick(1);
    chk("R5 obf_n low after write", obf_n, 0);
    chk("R5 pin_out loaded", pin_out, 8'h5A);
    host_rd_n = 1'b0; tick(4);
    host_rd_n = 1'b1; tick(4);
    chk("R13 read ignored ibf", ibf, 0);
    chk("R13 read leaves obf_n", obf_n, 0);
    strobe_n = 1'b0; tick(4);
    chk("R5 ack releases obf_n", obf_n, 1);
    chk("R13 ack not a strobe", ibf, 0);
    strobe_n = 1'b1; tick(4);
    chk("R6 intr after ack end", intr, 1);
    chk("R11 status output", status, 4'b1110);
    host_wdata = 8'h5B; host_wr_n = 1'b0; tick(4);
    chk("R6 write start clears intr", intr, 0);
    host_wr_n = 1'b1; tick(4);
    chk("R5 second word", pin_out, 8'h5B);
  endtask

  task automatic t_out_race;
    host_wr_n = 1'b0; tick(4);
    host_wr_n = 1'b1; strobe_n = 1'b0; host_wdata = 8'hC3;
    tick(4);
    chk("R10 write beats ack", obf_n, 0);
    chk("R10 word taken", pin_out, 8'hC3);
    strobe_n = 1'b1; tick(4);
    strobe_n = 1'b0; tick(4);
    chk("R5 ack releases", obf_n, 1);
    strobe_n = 1'b1; host_wr_n = 1'b0;
    tick(4);
    chk("R10 write start beats ack end", intr, 0);
    host_wr_n = 1'b1; tick(4);
    mode_out = 1'b0; tick(2);
    chk("R11 out latch flushed", pin_out, 0);
    chk("R11 obf_n idle", obf_n, 1);
    chk("R11 enable kept", status, 4'b0100);
  endtask

  initial begin
    rst_n = 1'b0; mode_out = 1'b0;
    host_rd_n = 1'b1; host_wr_n = 1'b1; host_wdata = '0;
    inte_set = 1'b0; inte_clr = 1'b0;
    strobe_n = 1'b1; pin_in = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_in_basic();
    t_in_overwrite();
    t_inte();
    t_in_race();
    t_mode_switch_in();
    t_out_basic();
    t_out_race();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule